// File: doc/BRIEF.md
# SECDED Read Checker with Error Address Capture

This block sits on the read path of a memory that stores an 8-bit check code beside every 64-bit word. On each read it recomputes the check code, locates and repairs any single flipped bit, and recognises words that carry two flipped bits. The repaired word leaves the block one clock after the read, together with one-cycle strobes for correctable and uncorrectable errors. An error-collection module consumes those strobes. The same strobes drive an active-low error pin.

Two independent capture registers hold the 64-bit-aligned address of a correctable error and of an uncorrectable error. Each register locks on its first error. It stays locked until software writes 1 to its status bit. Reads tagged as coming from the one-time-programmable region report errors only while a 4-bit key field of the control input holds the opening value. A separate enable bit turns checking off entirely.

Top module: `ecc_read_checker`

## Requirements
- R1: The stored code uses Hamming positions 1..71. Check bit i (rd_chk[i], i = 0..6) sits at position 2^i. The data bits rd_data[0..63] fill the remaining positions in ascending order. rd_chk[7] makes the parity of all 72 bits even. A word that matches its code is returned unchanged, with both strobes low. Every response (rsp_valid, rsp_data, strobes) appears exactly one clock after rd_valid, and rsp_valid is low after a cycle with no read.
- R2: A word with one flipped data bit is returned repaired, and rsp_sbe pulses for that response.
- R3: A word whose only flipped bit lies in the check byte (including rd_chk[7]) raises rsp_sbe, and the data is returned unchanged.
- R4: A word with two flipped bits raises rsp_dbe and is returned as read, without modification. rsp_sbe and rsp_dbe are never high together.
- R5: err_n is low exactly in the response cycle of a reported error and high otherwise.
- R6: A reported correctable error sets cor_flag and loads cor_addr with rd_addr, with its low 3 bits cleared.
- R7: A reported uncorrectable error sets unc_flag and loads unc_addr with the aligned address, and leaves the correctable capture untouched.
- R8: While a flag is set, later errors of the same kind still pulse their strobe but do not change the captured address.
- R9: A clr_wr cycle clears cor_flag where clr_mask[0] is 1 and unc_flag where clr_mask[1] is 1. A 0 mask bit leaves its flag alone. An error in the same cycle as its clear is captured.
- R10: With rd_otp high, errors are reported (strobes, pin, capture) only when cfg_otp_key equals 4'h9. Otherwise the data is still repaired but nothing is reported.
- R11: With cfg_chk_en low, data passes raw and no error is reported.
- R12: After reset, rsp_valid, both strobes and both flags are low, both addresses are zero and err_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | Read word present this cycle |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_otp | input | 1 | Read targets the one-time-programmable region |
| rd_data | input | 64 | Raw data word |
| rd_chk | input | 8 | Stored check code |
| cfg_chk_en | input | 1 | Checking enable |
| cfg_otp_key | input | 4 | Key that opens reporting for the one-time-programmable region |
| clr_wr | input | 1 | Write strobe for the status clear |
| clr_mask | input | 2 | Write-1-to-clear bits: [0] correctable, [1] uncorrectable |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 64 | Repaired data |
| rsp_sbe | output | 1 | Correctable error strobe |
| rsp_dbe | output | 1 | Uncorrectable error strobe |
| err_n | output | 1 | Active-low error pin |
| cor_flag | output | 1 | Correctable capture holds an address |
| cor_addr | output | ADDR_W | Aligned address of the captured correctable error |
| unc_flag | output | 1 | Uncorrectable capture holds an address |
| unc_addr | output | ADDR_W | Aligned address of the captured uncorrectable error |

## Verification
The bench flips bits in the check byte, including the overall parity bit and a pair of check bits. A decoder that assumes every flip lands in the data would corrupt the word or misclassify the pair. It issues a second error of the same kind while a capture is locked; a design without the lock would overwrite the first address. It clears one flag and errors in the same cycle; a design that lets the clear win would lose that error. It also sends one-time-programmable reads with the wrong and right key; a design that skips the key check would report the first, and one that gates correction with the key would return bad data.

// File: rtl/secded_pkg.sv
package secded_pkg;
    localparam int DATA_W   = 64;
    localparam int CHK_W    = 8;
    localparam int SYN_W    = CHK_W - 1;
    localparam int CODE_W   = DATA_W + SYN_W;
    localparam int ALIGN_W  = $clog2(DATA_W / 8);
    localparam int CLR_COR  = 0;
    localparam int CLR_UNC  = 1;

    typedef enum logic [1:0] {
        ECC_CLEAN  = 2'd0,
        ECC_SINGLE = 2'd1,
        ECC_DOUBLE = 2'd2
    } ecc_class_e;

    // Hamming position of data bit idx: the idx-th non-power-of-two position.
    function automatic int data_pos(input int idx);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int p = 1; p <= CODE_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == idx) res = p;
                cnt++;
            end
        end
        return res;
    endfunction

    // Data bits covered by Hamming check bit k.
    function automatic logic [DATA_W-1:0] cover_mask(input int k);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int j = 0; j < DATA_W; j++) begin
            m[j] = ((data_pos(j) >> k) & 1) != 0;
        end
        return m;
    endfunction
endpackage

// File: rtl/secded_syndrome.sv
module secded_syndrome
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  logic [CHK_W-1:0]  chk,
    output logic [SYN_W-1:0]  syn,
    output logic              par_odd
);
    for (genvar k = 0; k < SYN_W; k++) begin : g_syn
        localparam logic [DATA_W-1:0] COVER = cover_mask(k);
        assign syn[k] = (^(data & COVER)) ^ chk[k];
    end

    assign par_odd = (^data) ^ (^chk);
endmodule

// File: rtl/secded_fix.sv
module secded_fix
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  logic [SYN_W-1:0]  syn,
    input  logic              par_odd,
    output logic [DATA_W-1:0] data_fix,
    output ecc_class_e        cls
);
    logic [DATA_W-1:0] flip;

    for (genvar j = 0; j < DATA_W; j++) begin : g_flip
        localparam int POS = data_pos(j);
        assign flip[j] = par_odd && (syn == SYN_W'(POS));
    end

    assign data_fix = data ^ flip;

    always_comb begin
        if (!par_odd) begin
            cls = (syn == '0) ? ECC_CLEAN : ECC_DOUBLE;
        end else if (32'(syn) > CODE_W) begin
            cls = ECC_DOUBLE;
        end else begin
            cls = ECC_SINGLE;
        end
    end
endmodule

// File: rtl/ecc_capture.sv
module ecc_capture
    import secded_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              log_sbe,
    input  logic              log_dbe,
    input  logic [ADDR_W-1:0] log_addr,
    input  logic              clr_wr,
    input  logic [1:0]        clr_mask,
    output logic              cor_flag,
    output logic [ADDR_W-1:0] cor_addr,
    output logic              unc_flag,
    output logic [ADDR_W-1:0] unc_addr
);
    typedef struct packed {
        logic              cf;
        logic [ADDR_W-1:0] ca;
        logic              uf;
        logic [ADDR_W-1:0] ua;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        logic clr_c;
        logic clr_u;
        cap_d = cap_q;
        clr_c = clr_wr && clr_mask[CLR_COR];
        clr_u = clr_wr && clr_mask[CLR_UNC];
        if (clr_c) cap_d.cf = 1'b0;
        if (clr_u) cap_d.uf = 1'b0;
        // A capture is open when empty or being cleared in this cycle.
        if (log_sbe && (!cap_q.cf || clr_c)) begin
            cap_d.cf = 1'b1;
            cap_d.ca = log_addr;
        end
        if (log_dbe && (!cap_q.uf || clr_u)) begin
            cap_d.uf = 1'b1;
            cap_d.ua = log_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign cor_flag = cap_q.cf;
    assign cor_addr = cap_q.ca;
    assign unc_flag = cap_q.uf;
    assign unc_addr = cap_q.ua;
endmodule

// File: rtl/ecc_read_checker.sv
module ecc_read_checker
    import secded_pkg::*;
#(
    parameter int           ADDR_W       = 32,
    parameter logic [3:0]   OTP_KEY_OPEN = 4'h9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_otp,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [CHK_W-1:0]  rd_chk,
    input  logic              cfg_chk_en,
    input  logic [3:0]        cfg_otp_key,
    input  logic              clr_wr,
    input  logic [1:0]        clr_mask,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_sbe,
    output logic              rsp_dbe,
    output logic              err_n,
    output logic              cor_flag,
    output logic [ADDR_W-1:0] cor_addr,
    output logic              unc_flag,
    output logic [ADDR_W-1:0] unc_addr
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'((1 << ALIGN_W) - 1);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              sbe;
        logic              dbe;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [SYN_W-1:0]  syn;
    logic              par_odd;
    logic [DATA_W-1:0] data_fix;
    ecc_class_e        cls;
    logic              report_ok;
    logic              sbe_now;
    logic              dbe_now;
    logic [ADDR_W-1:0] addr_al;

    secded_syndrome u_syn (
        .data    (rd_data),
        .chk     (rd_chk),
        .syn     (syn),
        .par_odd (par_odd)
    );

    secded_fix u_fix (
        .data     (rd_data),
        .syn      (syn),
        .par_odd  (par_odd),
        .data_fix (data_fix),
        .cls      (cls)
    );

    assign report_ok = cfg_chk_en && (!rd_otp || (cfg_otp_key == OTP_KEY_OPEN));
    assign sbe_now   = rd_valid && report_ok && (cls == ECC_SINGLE);
    assign dbe_now   = rd_valid && report_ok && (cls == ECC_DOUBLE);
    assign addr_al   = rd_addr & ~ALIGN_MASK;

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = rd_valid;
        rsp_d.sbe   = sbe_now;
        rsp_d.dbe   = dbe_now;
        if (rd_valid) begin
            rsp_d.data = cfg_chk_en ? data_fix : rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    ecc_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .log_sbe  (sbe_now),
        .log_dbe  (dbe_now),
        .log_addr (addr_al),
        .clr_wr   (clr_wr),
        .clr_mask (clr_mask),
        .cor_flag (cor_flag),
        .cor_addr (cor_addr),
        .unc_flag (unc_flag),
        .unc_addr (unc_addr)
    );

    assign rsp_valid = rsp_q.valid;
    assign rsp_data  = rsp_q.data;
    assign rsp_sbe   = rsp_q.sbe;
    assign rsp_dbe   = rsp_q.dbe;
    assign err_n     = ~(rsp_q.sbe | rsp_q.dbe);
endmodule

// File: rtl/ecc_read_checker_sva.sv
module ecc_read_checker_sva #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_valid,
    input logic              cfg_chk_en,
    input logic              clr_wr,
    input logic [1:0]        clr_mask,
    input logic              rsp_valid,
    input logic              rsp_sbe,
    input logic              rsp_dbe,
    input logic              err_n,
    input logic              cor_flag,
    input logic [ADDR_W-1:0] cor_addr,
    input logic              unc_flag,
    input logic [ADDR_W-1:0] unc_addr
);
    // R1
    rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rsp_valid);

    // R1
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> !rsp_valid);

    // R4
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_sbe && rsp_dbe));

    // R5
    pin_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_n |-> rsp_valid);

    // R6
    sbe_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_sbe |-> cor_flag);

    // R7
    dbe_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_dbe |-> unc_flag);

    // R8
    cor_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cor_flag && !(clr_wr && clr_mask[0])) |=> $stable(cor_addr));

    // R8
    unc_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unc_flag && !(clr_wr && clr_mask[1])) |=> $stable(unc_addr));

    // R11
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !cfg_chk_en) |=> (!rsp_sbe && !rsp_dbe));
endmodule

bind ecc_read_checker ecc_read_checker_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_valid   (rd_valid),
    .cfg_chk_en (cfg_chk_en),
    .clr_wr     (clr_wr),
    .clr_mask   (clr_mask),
    .rsp_valid  (rsp_valid),
    .rsp_sbe    (rsp_sbe),
    .rsp_dbe    (rsp_dbe),
    .err_n      (err_n),
    .cor_flag   (cor_flag),
    .cor_addr   (cor_addr),
    .unc_flag   (unc_flag),
    .unc_addr   (unc_addr)
);

// File: tb/tb_ecc_read_checker.sv
module tb_ecc_read_checker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_addr = '0;
    logic        rd_otp = 1'b0;
    logic [63:0] rd_data = '0;
    logic [7:0]  rd_chk = '0;
    logic        cfg_chk_en = 1'b0;
    logic [3:0]  cfg_otp_key = '0;
    logic        clr_wr = 1'b0;
    logic [1:0]  clr_mask = '0;
    logic        rsp_valid, rsp_sbe, rsp_dbe, err_n, cor_flag, unc_flag;
    logic [63:0] rsp_data;
    logic [31:0] cor_addr, unc_addr;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ecc_read_checker dut (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .rd_otp(rd_otp), .rd_data(rd_data), .rd_chk(rd_chk),
        .cfg_chk_en(cfg_chk_en), .cfg_otp_key(cfg_otp_key),
        .clr_wr(clr_wr), .clr_mask(clr_mask), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_sbe(rsp_sbe), .rsp_dbe(rsp_dbe),
        .err_n(err_n), .cor_flag(cor_flag), .cor_addr(cor_addr),
        .unc_flag(unc_flag), .unc_addr(unc_addr)
    );

    typedef struct packed {
        logic [63:0] d;
        int          fa;
        int          fb;
        logic        otp;
        logic [3:0]  key;
        logic        en;
    } vec_t;

    // fa/fb: bit to flip in {chk,data} (0..63 data, 64..71 check), -1 none
    localparam int NV = 11;
    localparam vec_t VT [NV] = '{
        '{64'h0123_4567_89AB_CDEF, -1, -1, 1'b0, 4'h0, 1'b1},
        '{64'h0123_4567_89AB_CDEF,  0, -1, 1'b0, 4'h0, 1'b1},
        '{64'h0123_4567_89AB_CDEF,  0,  1, 1'b0, 4'h0, 1'b1},
        '{64'hFFFF_FFFF_FFFF_FFFF, 63, -1, 1'b0, 4'h0, 1'b1},
        '{64'h0000_0000_0000_0000, 66, -1, 1'b0, 4'h0, 1'b1},
        '{64'hA5A5_A5A5_A5A5_A5A5, 71, -1, 1'b0, 4'h0, 1'b1},
        '{64'h1234_5678_9ABC_DEF0, 10, 40, 1'b0, 4'h0, 1'b1},
        '{64'h0F0F_1234_0000_8001,  5, -1, 1'b1, 4'h0, 1'b1},
        '{64'h0F0F_1234_0000_8001,  5,  6, 1'b1, 4'h9, 1'b1},
        '{64'hDEAD_BEEF_0BAD_F00D,  7, -1, 1'b0, 4'h0, 1'b0},
        '{64'h5555_0000_AAAA_FFFF, 70, 71, 1'b0, 4'h0, 1'b1}
    };

    function automatic logic [7:0] encode(input logic [63:0] d);
        logic [6:0] h;
        int j;
        h = '0;
        j = 0;
        for (int p = 1; p <= 71; p++) begin
            if ((p & (p - 1)) != 0) begin
                for (int i = 0; i < 7; i++) if (p[i]) h[i] ^= d[j];
                j++;
            end
        end
        return {(^d) ^ (^h), h};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive_read(input logic [31:0] a, input logic [63:0] d,
                              input logic [7:0] c, input logic otp,
                              input logic [3:0] key, input logic en);
        @(negedge clk);
        rd_valid = 1'b1; rd_addr = a; rd_data = d; rd_chk = c;
        rd_otp = otp; cfg_otp_key = key; cfg_chk_en = en;
    endtask

    task automatic end_cycle;
        @(negedge clk);
        rd_valid = 1'b0; clr_wr = 1'b0; clr_mask = '0;
    endtask

    task automatic clear(input logic [1:0] m);
        @(negedge clk);
        clr_wr = 1'b1; clr_mask = m;
        end_cycle();
    endtask

    task automatic read_word(input logic [31:0] a, input logic [63:0] d, input int f);
        logic [71:0] w;
        w = {encode(d), d};
        if (f >= 0) w[f] = ~w[f];
        drive_read(a, w[63:0], w[71:64], 1'b0, 4'h0, 1'b1);
        end_cycle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [71:0] w;
        logic [31:0] a;
        int nf;
        logic rep;
        logic [63:0] exp_d;

        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12 rsp_valid", 64'(rsp_valid), 64'd0);
        check("R12 err_n", 64'(err_n), 64'd1);
        check("R12 flags", {62'd0, cor_flag, unc_flag}, 64'd0);
        check("R12 addrs", {cor_addr, unc_addr}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            clear(2'b11);
            w = {encode(VT[i].d), VT[i].d};
            nf = 0;
            if (VT[i].fa >= 0) begin w[VT[i].fa] = ~w[VT[i].fa]; nf++; end
            if (VT[i].fb >= 0) begin w[VT[i].fb] = ~w[VT[i].fb]; nf++; end
            a = 32'h0000_2000 + 32'(i * 16) + 32'(i % 8);
            rep = VT[i].en && (!VT[i].otp || VT[i].key == 4'h9);
            exp_d = (VT[i].en && nf <= 1) ? VT[i].d : w[63:0];
            drive_read(a, w[63:0], w[71:64], VT[i].otp, VT[i].key, VT[i].en);
            end_cycle();
            // R1 R2 R3 R10 R11: data; R4: double passes unmodified
            check($sformatf("R1/R2/R3/R4/R10/R11 data v%0d", i), rsp_data, exp_d);
            check($sformatf("R1 valid v%0d", i), 64'(rsp_valid), 64'd1);
            check($sformatf("R2/R3/R10 sbe v%0d", i), 64'(rsp_sbe), 64'(rep && nf == 1));
            check($sformatf("R4/R10 dbe v%0d", i), 64'(rsp_dbe), 64'(rep && nf == 2));
            check($sformatf("R5 err_n v%0d", i), 64'(err_n), 64'(!(rep && nf > 0)));
            check($sformatf("R6 cor_flag v%0d", i), 64'(cor_flag), 64'(rep && nf == 1));
            check($sformatf("R7 unc_flag v%0d", i), 64'(unc_flag), 64'(rep && nf == 2));
            if (rep && nf == 1) check($sformatf("R6 cor_addr v%0d", i), 64'(cor_addr), 64'(a & ~32'h7));
            if (rep && nf == 2) check($sformatf("R7 unc_addr v%0d", i), 64'(unc_addr), 64'(a & ~32'h7));
        end

        // R1: idle cycle drops rsp_valid, R5 pin high
        @(negedge clk);
        check("R1 idle valid", 64'(rsp_valid), 64'd0);
        check("R5 idle err_n", 64'(err_n), 64'd1);

        // R8: lock on first correctable and first uncorrectable address
        clear(2'b11);
        read_word(32'h0000_4013, 64'h1111_2222_3333_4444, 3);
        read_word(32'h0000_5027, 64'h1111_2222_3333_4444, 9);
        check("R8 sbe still pulses", 64'(rsp_sbe), 64'd1);
        check("R8 cor_addr locked", 64'(cor_addr), 64'h4010);
        drive_read(32'h0000_6008, 64'h0, 8'h03, 1'b0, 4'h0, 1'b1);
        end_cycle();
        check("R7 dbe from check pair", 64'(rsp_dbe), 64'd1);
        check("R7 cor untouched", 64'(cor_addr), 64'h4010);
        read_word(32'h0000_7000, 64'h0, 64 + 0);
        check("R3 check-byte single", 64'(rsp_sbe), 64'd1);
        check("R8 cor_addr still locked", 64'(cor_addr), 64'h4010);

        // R9: clearing one flag only
        clear(2'b10);
        check("R9 unc cleared", 64'(unc_flag), 64'd0);
        check("R9 cor kept", 64'(cor_flag), 64'd1);
        clear(2'b01);
        check("R9 cor cleared", 64'(cor_flag), 64'd0);
        read_word(32'h0000_8005, 64'h77, 20);
        check("R9 recapture after clear", 64'(cor_addr), 64'h8000);

        // R9: clear and new error in the same cycle, error wins
        w = {encode(64'h99), 64'h99};
        w[30] = ~w[30];
        drive_read(32'h0000_9ABF, w[63:0], w[71:64], 1'b0, 4'h0, 1'b1);
        clr_wr = 1'b1; clr_mask = 2'b01;
        end_cycle();
        check("R9 same-cycle flag", 64'(cor_flag), 64'd1);
        check("R9 same-cycle addr", 64'(cor_addr), 64'h9AB8);

        // R10: blocked OTP read leaves capture and pin alone
        clear(2'b11);
        w = {encode(64'h42), 64'h42};
        w[1] = ~w[1];
        drive_read(32'h0000_A000, w[63:0], w[71:64], 1'b1, 4'h8, 1'b1);
        end_cycle();
        check("R10 blocked data fixed", rsp_data, 64'h42);
        check("R10 blocked no flag", {62'd0, cor_flag, ~err_n}, 64'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule